// File: doc/BRIEF.md
# Video Memory Serial Access Port

This block is the serial side of a dual-port video memory. It keeps a 512-word by 4-bit serial buffer. Transfer cycles fill this buffer from a row of the random-access array, or copy it back to a row. An internal pointer picks the buffer word for each serial access, and a serial clock moves the pointer forward. The serial data path drives out or takes in data depending on the kind of transfer done last. A split transfer works on one half of the buffer only, so serial streaming can go on in the other half without a break.

The controls are sampled on a system clock. A transfer is decoded on the cycle where the row strobe is first seen low. The serial clock acts on the cycle where it is first seen high. The array row is presented as a flat vector on `row_rdata`. Write-backs come out on `row_wdata`, together with a per-half write strobe and the target row.

Top module: `vram_serial_port`

## Requirements
- R1: The pointer has 9 bits and wraps from word 511 to word 0 on the access after word 511.
- R2: Each rising serial clock edge advances the pointer by one. In input mode with `se` low, that edge also stores `sd_in` at the old pointer. In output mode, `sd_out` always shows the word at the pointer.
- R3: While `se` is high, `sd_oe` is low and no word is stored. Serial clock rises still advance the pointer.
- R4: A read transfer is `ras_n` falling with `cas_n` high, `dt_oe_n` low, `we_n` high and `dsf` low. It loads all 512 words from `row_rdata` (word i at bits 4i+3..4i), sets the pointer to 0, selects output mode and records `addr[8]`. `sd_oe` equals output mode and not `se`.
- R5: A pseudo transfer is `ras_n` falling with `cas_n` high, `dt_oe_n` low, `we_n` low, `dsf` low and `se` high. It selects input mode and writes no row.
- R6: A split write transfer is `ras_n` falling with `cas_n` high, `dt_oe_n` low, `we_n` low and `dsf` high. If it arrives in output mode, it is ignored: `xfer_err` pulses for one cycle and `row_we` stays 0.
- R7: A split write whose `addr[8]` differs from the value recorded by the last read or split read is ignored, and `xfer_err` pulses.
- R8: An accepted split write sets `row_we` for one cycle in the cycle after the fall. `row_we` is 2'b10 (upper half) when the pointer is in words 0..255, and 2'b01 (lower half) otherwise. `row_addr` is `addr`, and `row_wdata` holds the buffer image.
- R9: A split read is `ras_n` falling with `cas_n` high, `dt_oe_n` low, `we_n` high and `dsf` high. It loads only the half the pointer is not in. The pointer and the other half are left unchanged, output mode is selected and `addr[8]` is recorded.
- R10: A write transfer is `ras_n` falling with `cas_n` high, `dt_oe_n` low, `we_n` low, `dsf` low and `se` low. It sets `row_we` to 2'b11 for one cycle with `row_addr` equal to `addr`, selects input mode and clears the pointer. Serial clock rises are ignored while `ras_n` stays low.
- R11: After reset the port is in input mode, the pointer is 0, and `sd_oe`, `row_we` and `xfer_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, must be high for a transfer |
| dt_oe_n | input | 1 | Transfer select, low at row strobe fall |
| we_n | input | 1 | Write enable, active low |
| dsf | input | 1 | Special-function select |
| addr | input | 9 | Row address |
| sc | input | 1 | Serial clock |
| se | input | 1 | Serial disable, high tri-states the serial output |
| sd_in | input | 4 | Serial input data |
| sd_out | output | 4 | Serial output data |
| sd_oe | output | 1 | Serial output drive enable |
| row_rdata | input | 2048 | Array row contents for loads |
| row_addr | output | 9 | Row targeted by a write-back |
| row_wdata | output | 2048 | Buffer image for write-back |
| row_we | output | 2 | Per-half row write strobe (bit 1 upper) |
| xfer_err | output | 1 | One-cycle pulse on a rejected split write |

## Verification
The serial path is exercised in three ways: input words with the output enabled, input words with it disabled, and a full 512-step sweep after a read. These separate pointer motion from data capture and show the wrap point. Transfers are tried with two distinct row patterns. Because the patterns differ, a split read that loads the wrong half, or a full read, is caught at the 255/256 boundary. Split writes are tried in output mode, with a mismatched row MSB and in the valid case, so each rejection cause is seen on its own. A serial clock pulse sent while the row strobe stays low after a write transfer shows whether that window blocks accesses.

// File: rtl/vsp_pkg.sv
package vsp_pkg;
    typedef enum logic [2:0] {
        XF_NONE,
        XF_READ,
        XF_SPLIT_READ,
        XF_WRITE,
        XF_PSEUDO,
        XF_SPLIT_WRITE
    } xfer_e;
endpackage

// File: rtl/vsp_xfer_decode.sv
module vsp_xfer_decode
    import vsp_pkg::*;
(
    input  logic  ras_fall,
    input  logic  cas_n,
    input  logic  dt_oe_n,
    input  logic  we_n,
    input  logic  dsf,
    input  logic  se,
    output xfer_e kind
);
    always_comb begin
        kind = XF_NONE;
        if (ras_fall && cas_n && !dt_oe_n) begin
            case ({we_n, dsf})
                2'b10:   kind = XF_READ;
                2'b11:   kind = XF_SPLIT_READ;
                2'b01:   kind = XF_SPLIT_WRITE;
                default: kind = se ? XF_PSEUDO : XF_WRITE;
            endcase
        end
    end
endmodule

// File: rtl/vsp_buffer.sv
module vsp_buffer #(
    parameter int AW = 9,
    parameter int DW = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_idx,
    input  logic [DW-1:0]            wr_data,
    input  logic [1:0]               ld_mask,
    input  logic [(1<<AW)*DW-1:0]    ld_data,
    input  logic [AW-1:0]            rd_idx,
    output logic [DW-1:0]            rd_data,
    output logic [(1<<AW)*DW-1:0]    image
);
    localparam int DEPTH = 1 << AW;
    localparam int HALF  = DEPTH / 2;

    logic [DEPTH-1:0][DW-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        for (int h = 0; h < 2; h++) begin
            if (ld_mask[h]) begin
                for (int i = 0; i < HALF; i++) begin
                    mem_d[h*HALF + i] = ld_data[(h*HALF + i)*DW +: DW];
                end
            end
        end
        if (wr_en) begin
            mem_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign rd_data = mem_q[rd_idx];
    assign image   = mem_q;
endmodule

// File: rtl/vram_serial_port.sv
module vram_serial_port
    import vsp_pkg::*;
#(
    parameter int AW  = 9,
    parameter int DW  = 4,
    parameter int RAW = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ras_n,
    input  logic                     cas_n,
    input  logic                     dt_oe_n,
    input  logic                     we_n,
    input  logic                     dsf,
    input  logic [RAW-1:0]           addr,
    input  logic                     sc,
    input  logic                     se,
    input  logic [DW-1:0]            sd_in,
    output logic [DW-1:0]            sd_out,
    output logic                     sd_oe,
    input  logic [(1<<AW)*DW-1:0]    row_rdata,
    output logic [RAW-1:0]           row_addr,
    output logic [(1<<AW)*DW-1:0]    row_wdata,
    output logic [1:0]               row_we,
    output logic                     xfer_err
);
    typedef struct packed {
        logic           ras_q;
        logic           sc_q;
        logic           out_mode;
        logic [AW-1:0]  ptr;
        logic           row_msb;
        logic           blk;
        logic [1:0]     we;
        logic [RAW-1:0] waddr;
        logic           err;
    } state_t;

    state_t st_d, st_q;
    xfer_e  kind;
    logic   ras_fall, sc_rise, step;
    logic   wr_en;
    logic [1:0] ld_mask, far_half;

    assign ras_fall = st_q.ras_q & ~ras_n;
    assign sc_rise  = ~st_q.sc_q & sc;

    vsp_xfer_decode u_dec (
        .ras_fall (ras_fall),
        .cas_n    (cas_n),
        .dt_oe_n  (dt_oe_n),
        .we_n     (we_n),
        .dsf      (dsf),
        .se       (se),
        .kind     (kind)
    );

    always_comb begin
        st_d       = st_q;
        st_d.ras_q = ras_n;
        st_d.sc_q  = sc;
        st_d.we    = 2'b00;
        st_d.err   = 1'b0;
        st_d.blk   = st_q.blk & ~ras_n;
        ld_mask    = 2'b00;
        far_half   = st_q.ptr[AW-1] ? 2'b01 : 2'b10;

        step  = sc_rise & ~st_q.blk & (kind != XF_WRITE);
        wr_en = step & ~st_q.out_mode & ~se;
        if (step) st_d.ptr = st_q.ptr + 1'b1;

        case (kind)
            XF_READ: begin
                ld_mask       = 2'b11;
                st_d.out_mode = 1'b1;
                st_d.ptr      = '0;
                st_d.row_msb  = addr[RAW-1];
            end
            XF_SPLIT_READ: begin
                ld_mask       = far_half;
                st_d.out_mode = 1'b1;
                st_d.row_msb  = addr[RAW-1];
            end
            XF_WRITE: begin
                st_d.we       = 2'b11;
                st_d.waddr    = addr;
                st_d.out_mode = 1'b0;
                st_d.ptr      = '0;
                st_d.blk      = 1'b1;
            end
            XF_PSEUDO: begin
                st_d.out_mode = 1'b0;
            end
            XF_SPLIT_WRITE: begin
                if (st_q.out_mode || (addr[RAW-1] != st_q.row_msb)) begin
                    st_d.err = 1'b1;
                end else begin
                    st_d.we    = far_half;
                    st_d.waddr = addr;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.ras_q <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    vsp_buffer #(.AW(AW), .DW(DW)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (st_q.ptr),
        .wr_data (sd_in),
        .ld_mask (ld_mask),
        .ld_data (row_rdata),
        .rd_idx  (st_q.ptr),
        .rd_data (sd_out),
        .image   (row_wdata)
    );

    assign sd_oe    = st_q.out_mode & ~se;
    assign row_we   = st_q.we;
    assign row_addr = st_q.waddr;
    assign xfer_err = st_q.err;
endmodule

// File: rtl/vsp_checker.sv
module vsp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ras_n,
    input logic       cas_n,
    input logic       dt_oe_n,
    input logic       we_n,
    input logic       dsf,
    input logic       se,
    input logic       sd_oe,
    input logic [1:0] row_we,
    input logic       xfer_err
);
    assert_read_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && cas_n && !dt_oe_n && we_n && !dsf) |=> (se || sd_oe));

    assert_pseudo_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && cas_n && !dt_oe_n && !we_n && !dsf && se) |=> (!sd_oe && row_we == 2'b00));

    assert_split_wr_outmode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && cas_n && !dt_oe_n && !we_n && dsf && sd_oe) |=> xfer_err);

    assert_err_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_err |-> (row_we == 2'b00));

    assert_we_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (row_we != 2'b00) |=> (row_we == 2'b00));

    assert_we_after_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (row_we != 2'b00) |-> !$past(ras_n));
endmodule

bind vram_serial_port vsp_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .dt_oe_n  (dt_oe_n),
    .we_n     (we_n),
    .dsf      (dsf),
    .se       (se),
    .sd_oe    (sd_oe),
    .row_we   (row_we),
    .xfer_err (xfer_err)
);

// File: tb/vram_serial_port_test.sv
`timescale 1ns/1ps
module vram_serial_port_test;
    localparam int AW = 9, DW = 4, RAW = 9, DEPTH = 1 << AW;

    logic clk = 0, rst_n = 0;
    logic ras_n = 1, cas_n = 1, dt_oe_n = 1, we_n = 1, dsf = 0, sc = 0, se = 0;
    logic [RAW-1:0] addr = '0;
    logic [DW-1:0] sd_in = '0, sd_out;
    logic sd_oe, xfer_err;
    logic [DEPTH*DW-1:0] row_rdata = '0, row_wdata;
    logic [RAW-1:0] row_addr;
    logic [1:0] row_we;

    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    vram_serial_port #(.AW(AW), .DW(DW), .RAW(RAW)) uut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .dt_oe_n(dt_oe_n),
        .we_n(we_n), .dsf(dsf), .addr(addr), .sc(sc), .se(se), .sd_in(sd_in),
        .sd_out(sd_out), .sd_oe(sd_oe), .row_rdata(row_rdata), .row_addr(row_addr),
        .row_wdata(row_wdata), .row_we(row_we), .xfer_err(xfer_err)
    );

    function automatic logic [DW-1:0] pat(input bit sel, input int i);
        return sel ? DW'((i * 5 + 7) & 15) : DW'((i * 3 + 1) & 15);
    endfunction

    function automatic logic [DW-1:0] wword(input int i);
        return row_wdata[i*DW +: DW];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_pattern(input bit sel);
        for (int i = 0; i < DEPTH; i++) row_rdata[i*DW +: DW] = pat(sel, i);
    endtask

    task automatic sc_pulse(input logic [DW-1:0] d, input logic se_v);
        @(negedge clk); sd_in = d; se = se_v; sc = 1;
        @(posedge clk);
        @(negedge clk); sc = 0;
        @(posedge clk); #1;
    endtask

    task automatic ras_xfer(input logic w, input logic f, input logic se_v, input logic [RAW-1:0] a);
        @(negedge clk); ras_n = 0; dt_oe_n = 0; we_n = w; dsf = f; se = se_v; addr = a;
        @(posedge clk); #1;
    endtask

    task automatic ras_up();
        @(negedge clk); ras_n = 1; dt_oe_n = 1; we_n = 1; dsf = 0; se = 0;
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        chk(sd_oe == 0, "R11 sd_oe", 32'(sd_oe), 0);
        chk(row_we == 0, "R11 row_we", 32'(row_we), 0);
        chk(xfer_err == 0, "R11 xfer_err", 32'(xfer_err), 0);
    endtask

    task automatic t_input_and_write();
        sc_pulse(4'h3, 0);
        sc_pulse(4'hF, 1);
        sc_pulse(4'hA, 0);
        ras_xfer(0, 0, 0, 9'h055);
        chk(row_we == 2'b11, "R10 row_we", 32'(row_we), 3);
        chk(row_addr == 9'h055, "R10 row_addr", 32'(row_addr), 32'h55);
        chk(wword(0) == 4'h3, "R2 word0", 32'(wword(0)), 3);
        chk(wword(1) == 4'h0, "R3 skipped word1", 32'(wword(1)), 0);
        chk(wword(2) == 4'hA, "R2 word2", 32'(wword(2)), 32'hA);
        ras_up();
        chk(row_we == 0, "R10 pulse end", 32'(row_we), 0);
    endtask

    task automatic t_block_window();
        ras_xfer(0, 0, 0, 9'h011);
        sc_pulse(4'h9, 0);
        ras_up();
        sc_pulse(4'h6, 0);
        ras_xfer(0, 0, 0, 9'h012);
        chk(wword(0) == 4'h6, "R10 blocked sc", 32'(wword(0)), 6);
        chk(row_addr == 9'h012, "R10 row_addr2", 32'(row_addr), 32'h12);
        ras_up();
    endtask

    task automatic t_read_and_wrap();
        load_pattern(0);
        ras_xfer(1, 0, 0, 9'h1A0);
        chk(sd_oe == 1, "R4 sd_oe", 32'(sd_oe), 1);
        chk(sd_out == pat(0, 0), "R4 word0", 32'(sd_out), 32'(pat(0, 0)));
        chk(row_we == 0, "R4 no row write", 32'(row_we), 0);
        ras_up();
        sc_pulse(4'h0, 0);
        chk(sd_out == pat(0, 1), "R2 read step", 32'(sd_out), 32'(pat(0, 1)));
        for (int k = 0; k < 3; k++) sc_pulse(4'h0, 1);
        chk(sd_oe == 0, "R3 hiz", 32'(sd_oe), 0);
        @(negedge clk); se = 0; #1;
        chk(sd_oe == 1, "R4 drive again", 32'(sd_oe), 1);
        chk(sd_out == pat(0, 4), "R3 pointer advanced", 32'(sd_out), 32'(pat(0, 4)));
        for (int k = 4; k < 511; k++) sc_pulse(4'h0, 0);
        chk(sd_out == pat(0, 511), "R1 last word", 32'(sd_out), 32'(pat(0, 511)));
        sc_pulse(4'h0, 0);
        chk(sd_out == pat(0, 0), "R1 wrap", 32'(sd_out), 32'(pat(0, 0)));
    endtask

    task automatic t_split_read();
        load_pattern(1);
        ras_xfer(1, 1, 0, 9'h0C0);
        chk(sd_out == pat(0, 0), "R9 current half kept", 32'(sd_out), 32'(pat(0, 0)));
        chk(xfer_err == 0, "R9 no err", 32'(xfer_err), 0);
        ras_up();
        for (int k = 0; k < 255; k++) sc_pulse(4'h0, 0);
        chk(sd_out == pat(0, 255), "R9 word255 old", 32'(sd_out), 32'(pat(0, 255)));
        sc_pulse(4'h0, 0);
        chk(sd_out == pat(1, 256), "R9 word256 new", 32'(sd_out), 32'(pat(1, 256)));
    endtask

    task automatic t_split_write();
        ras_xfer(0, 1, 0, 9'h0D0);
        chk(xfer_err == 1, "R6 err in output mode", 32'(xfer_err), 1);
        chk(row_we == 0, "R6 ignored", 32'(row_we), 0);
        ras_up();
        chk(xfer_err == 0, "R6 err pulse end", 32'(xfer_err), 0);
        ras_xfer(0, 0, 1, 9'h000);
        chk(row_we == 0, "R5 no row write", 32'(row_we), 0);
        ras_up();
        chk(sd_oe == 0, "R5 input mode", 32'(sd_oe), 0);
        ras_xfer(0, 1, 0, 9'h1D0);
        chk(xfer_err == 1, "R7 msb mismatch err", 32'(xfer_err), 1);
        chk(row_we == 0, "R7 ignored", 32'(row_we), 0);
        ras_up();
        ras_xfer(0, 1, 0, 9'h0D5);
        chk(xfer_err == 0, "R8 accepted", 32'(xfer_err), 0);
        chk(row_we == 2'b01, "R8 lower half", 32'(row_we), 1);
        chk(row_addr == 9'h0D5, "R8 row_addr", 32'(row_addr), 32'hD5);
        chk(wword(10) == pat(0, 10), "R8 data", 32'(wword(10)), 32'(pat(0, 10)));
        ras_up();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        @(posedge clk); #1;
        t_reset();
        t_input_and_write();
        t_block_window();
        t_read_and_wrap();
        t_split_read();
        t_split_write();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule